// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches and unconditional jumps while the instruction sits in the decode stage of a five-stage pipeline. A conditional branch tests one source register against zero. The source can be the forwarded value. The test is either "equals zero" or "differs from zero". A dedicated adder in the same stage forms the taken target. Because both the test and the adder sit in decode, a taken branch costs one cycle and not three.

The unit chooses the next fetch address. It raises a one-cycle redirect strobe for every taken branch or jump. It also controls what enters the fetch/decode pipeline register. A mode input picks between two policies:

- **Predict-not-taken:** the instruction fetched after a taken branch is squashed. It is replaced by an all-zero no-operation word in the same cycle as the redirect.
- **Delayed-branch:** that instruction is kept and always executes, as a single delay slot.

Top module: `branch_resolver`

## Requirements
- R1: With branch kind 2'b01 (branch if zero), a valid, unstalled decode instruction redirects exactly when the source operand equals zero.
- R2: With branch kind 2'b10 (branch if non-zero), a valid, unstalled decode instruction redirects exactly when the source operand is not zero.
- R3: A taken conditional branch drives next_pc to the decode PC+4 plus the sign-extended instruction bits [15:0] shifted left by 2.
- R4: With branch kind 2'b11 (jump), a valid, unstalled decode instruction always redirects, and next_pc is decode PC+4 bits [31:28] followed by instruction bits [25:0] followed by two zero bits.
- R5: When no redirect occurs, next_pc equals the fetch-stage PC+4.
- R6: While id_stall is high or id_valid is low, redirect and flush stay low whatever the branch kind and operand.
- R7: In predict-not-taken mode (delay_mode = 0), a redirect raises flush_ifid in the same cycle, and ifid_instr_in is 32'h0000_0000.
- R8: In delayed-branch mode (delay_mode = 1), flush_ifid stays low, and ifid_instr_in equals fetch_instr even on a redirect.
- R9: Branch kind 2'b00 (not a branch) never redirects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| delay_mode | input | 1 | 1 = delayed branch with one slot, 0 = predict not taken |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_stall | input | 1 | Decode stage is stalled this cycle |
| br_kind | input | 2 | 00 none, 01 branch if zero, 10 branch if non-zero, 11 jump |
| id_instr | input | 32 | Instruction held in the fetch/decode pipeline register |
| id_pc4 | input | 32 | PC+4 of the decode instruction |
| src_val | input | 32 | Forwarded source operand tested against zero |
| fetch_pc4 | input | 32 | PC+4 of the instruction being fetched |
| fetch_instr | input | 32 | Instruction word being fetched |
| next_pc | output | 32 | Address for the next fetch |
| redirect | output | 1 | One-cycle strobe when control moves to a target |
| flush_ifid | output | 1 | Squash request for the fetch/decode register |
| ifid_instr_in | output | 32 | Word to load into the fetch/decode register |

## Verification
Directed cases separate the boundary conditions of the zero test:

- a zero operand against the operand 1 and the all-ones operand, so that a wrong polarity is exposed;
- a negative branch offset, which shows whether sign extension reaches the high bits of the target;
- a jump whose PC+4 has a non-zero top nibble, which shows whether those bits are kept;
- a stalled taken branch, which must not redirect.

Random cycles then mix all four branch kinds and both modes with operands that are zero about a quarter of the time. Each output is compared against a model in the bench, so a swap of the flush and delay-slot policies shows up in both directions.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int JMP_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            delay_mode,
  input  logic            id_valid,
  input  logic            id_stall,
  input  logic [1:0]      br_kind,
  input  logic [XLEN-1:0] id_instr,
  input  logic [XLEN-1:0] id_pc4,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] fetch_pc4,
  input  logic [XLEN-1:0] fetch_instr,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            flush_ifid,
  output logic [XLEN-1:0] ifid_instr_in
);
  localparam logic [1:0] K_NONE = 2'b00;
  localparam logic [1:0] K_BEQZ = 2'b01;
  localparam logic [1:0] K_BNEZ = 2'b10;
  localparam logic [1:0] K_JUMP = 2'b11;
  localparam int EXT_W = XLEN - 2 - IMM_W;
  localparam int HI_W  = XLEN - 2 - JMP_W;
  localparam logic [XLEN-1:0] NOP_WORD = '0;

  logic            is_zero;
  logic            cond_met;
  logic            live;
  logic [XLEN-1:0] br_offset;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  assign is_zero = (src_val == '0);
  assign live    = id_valid && !id_stall;

  always_comb begin
    case (br_kind)
      K_BEQZ:  cond_met = is_zero;
      K_BNEZ:  cond_met = !is_zero;
      K_JUMP:  cond_met = 1'b1;
      default: cond_met = 1'b0;
    endcase
  end

  assign br_offset  = {{EXT_W{id_instr[IMM_W-1]}}, id_instr[IMM_W-1:0], 2'b00};
  assign br_target  = id_pc4 + br_offset;
  assign jmp_target = {id_pc4[XLEN-1 -: HI_W], id_instr[JMP_W-1:0], 2'b00};

  assign redirect      = live && cond_met;
  assign next_pc       = !redirect ? fetch_pc4 :
                         (br_kind == K_JUMP) ? jmp_target : br_target;
  assign flush_ifid    = redirect && !delay_mode;
  assign ifid_instr_in = flush_ifid ? NOP_WORD : fetch_instr;

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_stall && br_kind == K_JUMP) |-> redirect);  // R4
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (id_stall || !id_valid) |-> (!redirect && !flush_ifid));  // R6
  AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !delay_mode) |-> (flush_ifid && ifid_instr_in == '0));  // R7
  AST_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    delay_mode |-> (!flush_ifid && ifid_instr_in == fetch_instr));  // R8
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == K_NONE) |-> !redirect);  // R9
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid || br_kind == K_NONE) |-> (next_pc == fetch_pc4));  // R5
endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  logic clk = 0, rst_n = 0;
  logic delay_mode, id_valid, id_stall;
  logic [1:0] br_kind;
  logic [31:0] id_instr, id_pc4, src_val, fetch_pc4, fetch_instr;
  logic [31:0] next_pc, ifid_instr_in;
  logic redirect, flush_ifid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_resolver uut (.*);

  function automatic bit m_taken();
    if (!id_valid || id_stall) return 0;
    case (br_kind)
      2'b01: return src_val == 0;
      2'b10: return src_val != 0;
      2'b11: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_pc();
    if (!m_taken()) return fetch_pc4;
    if (br_kind == 2'b11) return {id_pc4[31:28], id_instr[25:0], 2'b00};
    return id_pc4 + {{14{id_instr[15]}}, id_instr[15:0], 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(bit dm, bit v, bit st, logic [1:0] k, logic [31:0] ins,
                       logic [31:0] pc4, logic [31:0] sv, string tag);
    @(negedge clk);
    delay_mode = dm; id_valid = v; id_stall = st; br_kind = k;
    id_instr = ins; id_pc4 = pc4; src_val = sv;
    fetch_pc4 = pc4 + 4; fetch_instr = 32'hA5A5_0000 ^ ins;
    #1;
    chk({tag, " redirect"}, 32'(redirect), 32'(m_taken()));
    chk({tag, " next_pc"}, next_pc, m_pc());
    chk({tag, " flush"}, 32'(flush_ifid), 32'(m_taken() && !dm));
    chk({tag, " ifid"}, ifid_instr_in, (m_taken() && !dm) ? 32'h0 : fetch_instr);
  endtask

  initial begin
    delay_mode = 0; id_valid = 0; id_stall = 0; br_kind = 0;
    id_instr = 0; id_pc4 = 32'h100; src_val = 0; fetch_pc4 = 32'h104; fetch_instr = 32'h1234;
    #1;
    chk("R6 reset redirect", 32'(redirect), 0);
    chk("R5 reset next_pc", next_pc, 32'h104);
    repeat (3) @(posedge clk);
    rst_n = 1;
    apply(0, 1, 0, 2'b01, 32'h0000_0010, 32'h0000_1000, 0, "R1 beqz zero");
    chk("R3 fwd target", next_pc, 32'h0000_1040);
    apply(0, 1, 0, 2'b01, 32'h0000_0010, 32'h0000_1000, 1, "R1 beqz one");
    apply(0, 1, 0, 2'b10, 32'h0000_0010, 32'h0000_1000, 32'hFFFF_FFFF, "R2 bnez ones");
    apply(0, 1, 0, 2'b10, 32'h0000_0010, 32'h0000_1000, 0, "R2 bnez zero");
    apply(1, 1, 0, 2'b01, 32'h0000_FFFE, 32'h0000_1000, 0, "R3 back");
    chk("R3 neg target", next_pc, 32'h0000_0FF8);
    chk("R8 slot kept", ifid_instr_in, 32'hA5A5_FFFE);
    apply(0, 1, 0, 2'b11, 32'h03FF_FFFF, 32'hB000_0000, 5, "R4 jump");
    chk("R4 jump target", next_pc, 32'hBFFF_FFFC);
    chk("R7 squash nop", ifid_instr_in, 32'h0);
    apply(0, 1, 1, 2'b11, 32'h0000_0040, 32'h2000_0000, 0, "R6 stalled jump");
    apply(0, 0, 0, 2'b01, 32'h0000_0040, 32'h2000_0000, 0, "R6 invalid");
    apply(0, 1, 0, 2'b00, 32'h0000_0040, 32'h2000_0000, 0, "R9 none");
    chk("R5 seq pc", next_pc, 32'h2000_0004);
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] sv = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      apply(1'($urandom), ($urandom % 8) != 0, ($urandom % 6) == 0, 2'($urandom),
            $urandom, {$urandom & 32'hFFFF_FFFC}, sv, "R1/R2/R3/R4/R7/R8 rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule